// File: doc/BRIEF.md
# DMA Destination Burst Sequencer

This block is the destination half of one DMA channel. It moves a block of data items into a peripheral's transmit FIFO. The peripheral raises a request whenever its fill level drops to its watermark, and each request starts one burst of writes. Software loads the block length and the burst length and pulses `start`. From then on the sequencer waits for rising request edges. Each edge lets it write one burst, during which source items pass straight through to the destination. After the last item of the block it raises `done` for one cycle and returns to idle.

The intended setting makes the burst length equal to the FIFO depth minus the watermark, so that one burst exactly refills the space that was free when the request fired. Because of that, a request edge that arrives while a burst is still running carries no new information and is dropped. When the block length is not a whole number of bursts, the last burst writes only the items that remain. A zero block length or a zero burst length finishes at once and writes nothing.

Top module: `dst_burst_seq`

## Requirements
- R1: While and after a synchronous active-high reset, `busy`, `done` and `dst_wr` are all low until the next `start`.
- R2: A burst writes exactly min(burst length, items remaining) items, and then writes nothing more until a new request edge arrives.
- R3: A block takes ceil(block length / burst length) bursts; for example, 30 items in bursts of 6 take 5 bursts, and 7 items in bursts of 3 take 3 bursts.
- R4: A burst starts only on a request edge seen while the channel is waiting, meaning `periph_req` is high in a cycle and was low in the cycle before. A request held high starts only one burst.
- R5: A request edge seen during a burst is discarded, including one that falls in the cycle of the burst's final write. It does not start a later burst.
- R6: When the block length is not a multiple of the burst length, the final burst writes only the remaining item count.
- R7: `done` is high for exactly one cycle, the cycle after the block's last write. `busy` is low from the following cycle.
- R8: `dst_wr` is high only during a burst in a cycle where `src_valid` is high and `dst_full` is low. `src_ack` equals `dst_wr`, and `dst_data` equals `src_data`.
- R9: If the block length or the burst length is zero, `done` rises in the cycle after `start` and no write is issued.
- R10: A `start` pulse while `busy` is high is ignored. The running block keeps its own configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a block using the current configuration |
| cfg_block_len | input | CNT_W | Items in the block |
| cfg_burst_len | input | CNT_W | Items per burst |
| periph_req | input | 1 | Peripheral watermark request, level |
| src_valid | input | 1 | Source item available |
| src_data | input | DATA_W | Source item |
| src_ack | output | 1 | Source item consumed this cycle |
| dst_full | input | 1 | Destination FIFO cannot accept |
| dst_wr | output | 1 | Destination write strobe |
| dst_data | output | DATA_W | Destination write data |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle block completion pulse |

## Verification
Two things can land in the same cycle: the final write of a burst and a new rising request edge. The design must discard that edge, not carry it into the next wait. The bench provokes this by dropping the request during a running burst and raising it again exactly in the cycle of the fourth write. It then holds the request low for a full window and checks that no write appears, and it also checks that the next deliberate edge produces a complete burst.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    localparam int unsigned DBS_DATA_W = 32;
    localparam int unsigned DBS_CNT_W  = 16;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_BURST  = 2'd2,
        ST_FINISH = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic ld_blk;
        logic ld_burst;
        logic in_burst;
        logic busy;
        logic done;
    } seq_ctl_t;

endpackage

// File: rtl/dbs_req_edge.sv
module dbs_req_edge (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic req_rise
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= req;
    end

    assign req_rise = req & ~req_q;
endmodule

// File: rtl/dbs_counters.sv
module dbs_counters #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_blk,
    input  logic             cfg_zero,
    input  logic [CNT_W-1:0] blk_len,
    input  logic [CNT_W-1:0] burst_len,
    input  logic             ld_burst,
    input  logic             beat,
    output logic             last_beat,
    output logic             last_item,
    output logic [CNT_W-1:0] items_left,
    output logic [CNT_W:0]   bursts_left
);
    localparam int unsigned QW = CNT_W + 1;

    logic [CNT_W-1:0] beats_left;
    logic [CNT_W-1:0] burst_cfg;
    logic [QW-1:0]    sum_w;
    logic [QW-1:0]    quot_w;
    logic [CNT_W-1:0] next_burst;

    // ceil(blk/burst) computed once per block
    assign sum_w  = {1'b0, blk_len} + {1'b0, burst_len} - {{CNT_W{1'b0}}, 1'b1};
    assign quot_w = (burst_len == '0) ? '0 : (sum_w / {1'b0, burst_len});

    assign next_burst = (burst_cfg < items_left) ? burst_cfg : items_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            items_left  <= '0;
            beats_left  <= '0;
            bursts_left <= '0;
            burst_cfg   <= '0;
        end else if (ld_blk) begin
            items_left  <= cfg_zero ? '0 : blk_len;
            bursts_left <= cfg_zero ? '0 : quot_w;
            burst_cfg   <= burst_len;
            beats_left  <= '0;
        end else if (ld_burst) begin
            beats_left  <= next_burst;
        end else if (beat) begin
            items_left  <= items_left - 1'b1;
            beats_left  <= beats_left - 1'b1;
            if (beats_left == {{(CNT_W-1){1'b0}}, 1'b1})
                bursts_left <= bursts_left - 1'b1;
        end
    end

    assign last_beat = (beats_left == {{(CNT_W-1){1'b0}}, 1'b1});
    assign last_item = (items_left == {{(CNT_W-1){1'b0}}, 1'b1});

    // a fresh burst always has work to do
    p_burst_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
        ld_burst |=> beats_left != '0);

    // a burst is loaded only once the previous one is spent
    p_prev_spent_r5: assert property (@(posedge clk) disable iff (rst)
        ld_burst |-> beats_left == '0);

    // no write past the end of the block
    p_no_overrun_r6: assert property (@(posedge clk) disable iff (rst)
        beat |-> items_left != '0);
endmodule

// File: rtl/dbs_fsm.sv
module dbs_fsm
    import dbs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     cfg_zero,
    input  logic     req_rise,
    input  logic     beat,
    input  logic     last_beat,
    input  logic     last_item,
    output seq_ctl_t ctl
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        ctl     = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    ctl.ld_blk = 1'b1;
                    state_d    = cfg_zero ? ST_FINISH : ST_WAIT;
                end
            end
            ST_WAIT: begin
                ctl.busy = 1'b1;
                if (req_rise) begin
                    ctl.ld_burst = 1'b1;
                    state_d      = ST_BURST;
                end
            end
            ST_BURST: begin
                ctl.busy     = 1'b1;
                ctl.in_burst = 1'b1;
                if (beat && last_beat)
                    state_d = last_item ? ST_FINISH : ST_WAIT;
            end
            ST_FINISH: begin
                ctl.busy = 1'b1;
                ctl.done = 1'b1;
                state_d  = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        ctl.done |=> !ctl.done);

    p_start_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (ctl.busy && !ctl.done) |=> ctl.busy);
endmodule

// File: rtl/dst_burst_seq.sv
module dst_burst_seq
    import dbs_pkg::*;
#(
    parameter int unsigned DATA_W = DBS_DATA_W,
    parameter int unsigned CNT_W  = DBS_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  cfg_block_len,
    input  logic [CNT_W-1:0]  cfg_burst_len,
    input  logic              periph_req,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ack,
    input  logic              dst_full,
    output logic              dst_wr,
    output logic [DATA_W-1:0] dst_data,
    output logic              busy,
    output logic              done
);
    seq_ctl_t         ctl;
    logic             req_rise;
    logic             cfg_zero;
    logic             beat;
    logic             last_beat;
    logic             last_item;
    logic [CNT_W-1:0] items_left;
    logic [CNT_W:0]   bursts_left;

    assign cfg_zero = (cfg_block_len == '0) || (cfg_burst_len == '0);

    dbs_req_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .req      (periph_req),
        .req_rise (req_rise)
    );

    dbs_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cfg_zero  (cfg_zero),
        .req_rise  (req_rise),
        .beat      (beat),
        .last_beat (last_beat),
        .last_item (last_item),
        .ctl       (ctl)
    );

    dbs_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .ld_blk      (ctl.ld_blk),
        .cfg_zero    (cfg_zero),
        .blk_len     (cfg_block_len),
        .burst_len   (cfg_burst_len),
        .ld_burst    (ctl.ld_burst),
        .beat        (beat),
        .last_beat   (last_beat),
        .last_item   (last_item),
        .items_left  (items_left),
        .bursts_left (bursts_left)
    );

    assign beat     = ctl.in_burst & src_valid & ~dst_full;
    assign dst_wr   = beat;
    assign src_ack  = beat;
    assign dst_data = src_data;
    assign busy     = ctl.busy;
    assign done     = ctl.done;

    // every item and every burst is accounted for at completion
    p_block_drained_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (items_left == '0) && (bursts_left == '0));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !dst_wr);

    p_no_write_full_r8: assert property (@(posedge clk) disable iff (rst)
        dst_full |-> !dst_wr);
endmodule

// File: tb/tb_dst_burst_seq.sv
module tb_dst_burst_seq;
    localparam int unsigned DW = 32;
    localparam int unsigned CW = 16;

    // block length, burst length, stall mode (0 none, 1 valid every other cycle, 2 full every third cycle)
    localparam int unsigned NVEC = 6;
    localparam int unsigned VEC [NVEC][3] = '{
        '{30, 6, 0}, '{30, 6, 1}, '{7, 3, 2}, '{5, 8, 0}, '{1, 1, 1}, '{12, 4, 2}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [CW-1:0] cfg_block_len;
    logic [CW-1:0] cfg_burst_len;
    logic          periph_req;
    logic          src_valid;
    logic [DW-1:0] src_data;
    logic          src_ack;
    logic          dst_full;
    logic          dst_wr;
    logic [DW-1:0] dst_data;
    logic          busy;
    logic          done;

    int n_total = 0, n_fail = 0;
    int tick_n = 0, n_wr = 0, n_done = 0, last_wr = -1, done_at = -1;
    int data_bad = 0, gate_bad = 0;

    always #10 clk = ~clk;

    dst_burst_seq dut (
        .clk(clk), .rst(rst), .start(start),
        .cfg_block_len(cfg_block_len), .cfg_burst_len(cfg_burst_len),
        .periph_req(periph_req), .src_valid(src_valid), .src_data(src_data),
        .src_ack(src_ack), .dst_full(dst_full), .dst_wr(dst_wr),
        .dst_data(dst_data), .busy(busy), .done(done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic st, input logic rq, input logic sv, input logic fl);
        @(negedge clk);
        start = st; periph_req = rq; src_valid = sv; dst_full = fl;
        src_data = DW'(tick_n * 7 + 3);
        #1;
        if (dst_wr) begin
            n_wr++;
            last_wr = tick_n;
            if (dst_data != src_data || src_ack != 1'b1) data_bad++;
            if (fl || !sv) gate_bad++;
        end else if (src_ack) data_bad++;
        if (done) begin n_done++; done_at = tick_n; end
        tick_n++;
    endtask

    function automatic logic sv_of(input int unsigned m, input int t);
        return (m == 1) ? ((t % 2) == 0) : 1'b1;
    endfunction

    function automatic logic fl_of(input int unsigned m, input int t);
        return (m == 2) ? ((t % 3) == 0) : 1'b0;
    endfunction

    task automatic clear_stats();
        n_wr = 0; n_done = 0; last_wr = -1; done_at = -1; data_bad = 0; gate_bad = 0;
    endtask

    // one request window: req high in first cycle only, returns writes seen
    task automatic window(input int len, input int unsigned m, output int got);
        int w0;
        w0 = n_wr;
        for (int k = 0; k < len; k++) cyc(1'b0, k == 0, sv_of(m, tick_n), fl_of(m, tick_n));
        got = n_wr - w0;
    endtask

    task automatic run_block(input int unsigned blk, input int unsigned bst, input int unsigned m);
        int exp_b, got, nb, rem;
        clear_stats();
        cfg_block_len = CW'(blk); cfg_burst_len = CW'(bst);
        cyc(1'b1, 1'b0, 1'b1, 1'b0);
        exp_b = (blk + bst - 1) / bst;
        nb = 0;
        rem = blk;
        for (int b = 0; b < exp_b + 1; b++) begin
            window(3 * bst + 6, m, got);
            if (got != 0) nb++;
            if (b < exp_b)
                chk($sformatf("R2/R6 burst %0d of block %0d/%0d", b, blk, bst), got, (rem < bst) ? rem : bst);
            else
                chk("R5 no write without new burst after block", got, 0);
            rem = rem - ((rem < bst) ? rem : bst);
        end
        chk($sformatf("R3 burst count %0d/%0d", blk, bst), nb, exp_b);
        chk("R7 done pulse count", n_done, 1);
        chk("R7 done one cycle after last write", done_at, last_wr + 1);
        chk("R8 data passthrough and ack", data_bad, 0);
        chk("R8 write gated by valid and full", gate_bad, 0);
        chk("R7 idle after done", int'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        int got;
        rst = 1'b1; start = 1'b0; periph_req = 1'b0; src_valid = 1'b0; dst_full = 1'b0;
        src_data = '0; cfg_block_len = '0; cfg_burst_len = '0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 done in reset", int'(done), 0);
        chk("R1 dst_wr in reset", int'(dst_wr), 0);
        @(negedge clk); rst = 1'b0;
        // a request with no block running writes nothing
        clear_stats();
        cfg_block_len = 16'd4; cfg_burst_len = 16'd2;
        window(8, 0, got);
        chk("R1 no write before start", got, 0);
        chk("R1 busy stays low before start", int'(busy), 0);

        // table of vectors
        for (int v = 0; v < int'(NVEC); v++) run_block(VEC[v][0], VEC[v][1], VEC[v][2]);

        // R9 zero block length and zero burst length
        for (int z = 0; z < 2; z++) begin
            int t0;
            clear_stats();
            cfg_block_len = (z == 0) ? 16'd0 : 16'd5;
            cfg_burst_len = (z == 0) ? 16'd4 : 16'd0;
            t0 = tick_n;
            cyc(1'b1, 1'b0, 1'b1, 1'b0);
            window(10, 0, got);
            chk("R9 zero config no writes", n_wr, 0);
            chk("R9 zero config done cycle", done_at, t0 + 1);
            chk("R9 zero config single done", n_done, 1);
        end

        // R4 held request: one burst only
        clear_stats();
        cfg_block_len = 16'd8; cfg_burst_len = 16'd4;
        cyc(1'b1, 1'b0, 1'b1, 1'b0);
        for (int k = 0; k < 30; k++) cyc(1'b0, 1'b1, 1'b1, 1'b0);
        chk("R4 held request gives one burst", n_wr, 4);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        // R10 start while busy with a different config is ignored
        cfg_block_len = 16'd2; cfg_burst_len = 16'd1;
        cyc(1'b1, 1'b0, 1'b1, 1'b0);
        window(12, 0, got);
        chk("R10 running config kept", got, 4);
        chk("R10 block done once", n_done, 1);

        // R5 edge during stalled burst and on final write
        clear_stats();
        cfg_block_len = 16'd8; cfg_burst_len = 16'd4;
        cyc(1'b1, 1'b0, 1'b1, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0);               // edge: burst loads
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0);               // edge inside stalled burst
        cyc(1'b0, 1'b0, 1'b1, 1'b0);               // write 1
        cyc(1'b0, 1'b0, 1'b1, 1'b0);               // write 2
        cyc(1'b0, 1'b0, 1'b1, 1'b0);               // write 3
        cyc(1'b0, 1'b1, 1'b1, 1'b0);               // write 4 with a fresh edge
        chk("R5 first burst length", n_wr, 4);
        for (int k = 0; k < 15; k++) cyc(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R5 edge in burst dropped", n_wr, 4);
        window(12, 0, got);
        chk("R5 next edge gives full burst", got, 4);
        chk("R7 done after second burst", n_done, 1);
        chk("R7 done timing", done_at, last_wr + 1);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule